// File: doc/BRIEF.md
# Branch Direction Predictor with Target Cache

The block sits in the fetch stage of a pipelined processor. A direct-mapped table, addressed by the low-order bits of the fetch address, holds one entry per slot. Each entry has a valid flag, a two-bit saturating confidence counter and the last target seen for a branch at that slot. At fetch, the block reads the table in the same cycle and returns two things: a taken/not-taken guess and the next fetch address. The next fetch address is the cached target on a taken guess and the sequential address (PC+4) otherwise. The surrounding fetch logic uses that address as the next PC. The guess and the address then travel down the pipe with the instruction.

When the branch resolves, the pipeline presents the branch address, the real outcome, the real target and the guess that was carried along. In that same cycle the block raises a mispredict flag, so that fetch can restart on the right path. At the next clock edge it writes back the new counter value, the target and the valid flag. Two branches whose addresses share the index bits use the same entry. This costs accuracy but never correctness. Flushing the pipe and the instruction memory are outside the block.

Top module: `branch_predictor_btb`

## Requirements
- R1: After reset every entry is invalid with counter 01, so every lookup returns pred_taken_o=0 and pred_target_o=fetch_pc_i+4.
- R2: The entry index is PC bits [IDX_W+1:2]. Addresses that differ only above those bits, or only in bits [1:0], use the same entry.
- R3: A taken update raises the entry counter by one and saturates at 11. Encoding: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken.
- R4: A not-taken update lowers the entry counter by one and saturates at 00.
- R5: The guess is counter bit 1 of a valid entry. From a strong state, the guess flips only after two opposite outcomes in a row.
- R6: On a taken guess, pred_target_o is the target from the last update of that entry. On a not-taken guess, it is fetch_pc_i+4.
- R7: The first update of an invalid entry counts from 01 and marks the entry valid, so one taken outcome makes it guess taken.
- R8: mispredict_o is combinational from the update port. It is 1 when upd_valid_i is 1 and either the outcome differs from upd_pred_taken_i, or both are taken and upd_target_i differs from upd_pred_target_i. It is 0 whenever upd_valid_i is 0.
- R9: An update is written at the clock edge. A lookup of the same entry in the update cycle returns the old contents, and the new contents are visible from the next cycle on.
- R10: An update changes only the entry it indexes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | PC_W | Address being fetched |
| pred_taken_o | output | 1 | Guess that the fetched instruction is a taken branch |
| pred_target_o | output | PC_W | Next fetch address |
| upd_valid_i | input | 1 | A branch resolves this cycle |
| upd_pc_i | input | PC_W | Address of the resolving branch |
| upd_taken_i | input | 1 | Real outcome |
| upd_target_i | input | PC_W | Real taken target of the branch |
| upd_pred_taken_i | input | 1 | Guess carried with the branch |
| upd_pred_target_i | input | PC_W | Next-address guess carried with the branch |
| mispredict_o | output | 1 | Guess was wrong; restart fetch |

## Verification
Lookups and the mispredict flag are combinational, so both are due in the cycle their inputs are applied. The bench sets inputs just after a falling edge and samples 1 ns later, before the next rising edge. An update takes effect at the first rising edge after it is presented. The bench samples the same entry in the update cycle and expects the old contents there. It then looks the entry up again at the following falling edge and expects the new contents. A reference table in the bench is updated only after that rising edge, so its expected values always trail the design by exactly the one-edge write latency.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  localparam int unsigned OFS_W   = 2;
  localparam int unsigned PC_STEP = 4;
endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 10
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned LO = bp_pkg::OFS_W;

  assign idx_o = pc_i[IDX_W+LO-1:LO];

  logic pc_unused;
  assign pc_unused = ^{pc_i[PC_W-1:IDX_W+LO], pc_i[LO-1:0]};
endmodule

// File: rtl/bp_ctr_next.sv
module bp_ctr_next
  import bp_pkg::*;
(
  input  ctr_e ctr_i,
  input  logic taken_i,
  output ctr_e ctr_o
);
  always_comb begin
    ctr_o = ctr_i;
    if (taken_i) begin
      if (ctr_i != CTR_ST) ctr_o = ctr_e'(ctr_i + 2'd1);
    end else begin
      if (ctr_i != CTR_SNT) ctr_o = ctr_e'(ctr_i - 2'd1);
    end
  end
endmodule

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int unsigned ENTRIES = 1024,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned PC_W    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] fetch_idx_i,
  output logic             fetch_vld_o,
  output ctr_e             fetch_ctr_o,
  output logic [PC_W-1:0]  fetch_tgt_o,
  input  logic [IDX_W-1:0] upd_idx_i,
  output logic             upd_vld_o,
  output ctr_e             upd_ctr_o,
  input  logic             wr_en_i,
  input  ctr_e             wr_ctr_i,
  input  logic [PC_W-1:0]  wr_tgt_i
);
  logic [ENTRIES-1:0] vld_q;
  ctr_e               ctr_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic hit;
    assign hit = wr_en_i && (upd_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        ctr_q[g] <= CTR_WNT;
      end else if (hit) begin
        vld_q[g] <= 1'b1;
        ctr_q[g] <= wr_ctr_i;
      end
    end

    // target storage needs no reset: masked by vld_q
    always_ff @(posedge clk_i) begin
      if (hit) tgt_q[g] <= wr_tgt_i;
    end
  end

  assign fetch_vld_o = vld_q[fetch_idx_i];
  assign fetch_ctr_o = ctr_q[fetch_idx_i];
  assign fetch_tgt_o = tgt_q[fetch_idx_i];
  assign upd_vld_o   = vld_q[upd_idx_i];
  assign upd_ctr_o   = ctr_q[upd_idx_i];
endmodule

// File: rtl/branch_predictor_btb.sv
module branch_predictor_btb
  import bp_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 1024
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            pred_taken_o,
  output logic [PC_W-1:0] pred_target_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_target_i,
  input  logic            upd_pred_taken_i,
  input  logic [PC_W-1:0] upd_pred_target_i,
  output logic            mispredict_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] fetch_idx, upd_idx;
  logic             fetch_vld, upd_vld;
  ctr_e             fetch_ctr, upd_ctr, upd_base, upd_next;
  logic [PC_W-1:0]  fetch_tgt;

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fetch_idx (
    .pc_i(fetch_pc_i), .idx_o(fetch_idx)
  );

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_upd_idx (
    .pc_i(upd_pc_i), .idx_o(upd_idx)
  );

  bp_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .PC_W(PC_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_idx_i (fetch_idx),
    .fetch_vld_o (fetch_vld),
    .fetch_ctr_o (fetch_ctr),
    .fetch_tgt_o (fetch_tgt),
    .upd_idx_i   (upd_idx),
    .upd_vld_o   (upd_vld),
    .upd_ctr_o   (upd_ctr),
    .wr_en_i     (upd_valid_i),
    .wr_ctr_i    (upd_next),
    .wr_tgt_i    (upd_target_i)
  );

  // an untouched entry counts from weak not-taken
  assign upd_base = upd_vld ? upd_ctr : CTR_WNT;

  bp_ctr_next u_ctr_next (
    .ctr_i   (upd_base),
    .taken_i (upd_taken_i),
    .ctr_o   (upd_next)
  );

  assign pred_taken_o  = fetch_vld && fetch_ctr[1];
  assign pred_target_o = pred_taken_o ? fetch_tgt : fetch_pc_i + PC_W'(PC_STEP);

  assign mispredict_o = upd_valid_i &&
                        ((upd_taken_i != upd_pred_taken_i) ||
                         (upd_taken_i && upd_pred_taken_i &&
                          (upd_target_i != upd_pred_target_i)));
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] fetch_pc_i,
  input logic            pred_taken_o,
  input logic [PC_W-1:0] pred_target_o,
  input logic            upd_valid_i,
  input logic [PC_W-1:0] upd_pc_i,
  input logic            upd_taken_i,
  input logic [PC_W-1:0] upd_target_i,
  input logic            upd_pred_taken_i,
  input logic [PC_W-1:0] upd_pred_target_i,
  input logic            mispredict_o
);
  logic [IDX_W-1:0] f_idx, u_idx;
  logic             same_idx;
  assign f_idx    = fetch_pc_i[IDX_W+1:2];
  assign u_idx    = upd_pc_i[IDX_W+1:2];
  assign same_idx = (f_idx == u_idx);

  logic chk_unused;
  assign chk_unused = ^{upd_pc_i[PC_W-1:IDX_W+2], upd_pc_i[1:0]};

  a_r8_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |-> !mispredict_o);

  a_r8_direction_wrong: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && (upd_taken_i != upd_pred_taken_i)) |-> mispredict_o);

  a_r8_target_wrong: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && upd_pred_taken_i &&
     (upd_target_i != upd_pred_target_i)) |-> mispredict_o);

  a_r6_fallthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_taken_o |-> (pred_target_o == fetch_pc_i + PC_W'(4)));

  a_r3_taken_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && same_idx && pred_taken_o) |=>
      ((f_idx != $past(u_idx)) ||
       (pred_taken_o && (pred_target_o == $past(upd_target_i)))));

  a_r4_not_taken_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i && same_idx && !pred_taken_o) |=>
      ((f_idx != $past(u_idx)) || !pred_taken_o));
endmodule

bind branch_predictor_btb bp_checker #(.PC_W(PC_W), .IDX_W(IDX_W)) u_bp_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .fetch_pc_i        (fetch_pc_i),
  .pred_taken_o      (pred_taken_o),
  .pred_target_o     (pred_target_o),
  .upd_valid_i       (upd_valid_i),
  .upd_pc_i          (upd_pc_i),
  .upd_taken_i       (upd_taken_i),
  .upd_target_i      (upd_target_i),
  .upd_pred_taken_i  (upd_pred_taken_i),
  .upd_pred_target_i (upd_pred_target_i),
  .mispredict_o      (mispredict_o)
);

// File: tb/branch_predictor_btb_tb.sv
`timescale 1ns/1ps
module branch_predictor_btb_tb;
  localparam int unsigned PC_W = 32;
  localparam int unsigned ENT  = 16;
  localparam int unsigned IW   = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [PC_W-1:0] fetch_pc_i = '0;
  logic            pred_taken_o;
  logic [PC_W-1:0] pred_target_o;
  logic            upd_valid_i = 1'b0;
  logic [PC_W-1:0] upd_pc_i = '0;
  logic            upd_taken_i = 1'b0;
  logic [PC_W-1:0] upd_target_i = '0;
  logic            upd_pred_taken_i = 1'b0;
  logic [PC_W-1:0] upd_pred_target_i = '0;
  logic            mispredict_o;

  always #2.5 clk_i = ~clk_i;

  branch_predictor_btb #(.PC_W(PC_W), .ENTRIES(ENT)) u_dut (.*);

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  logic            m_vld [ENT];
  logic [1:0]      m_ctr [ENT];
  logic [PC_W-1:0] m_tgt [ENT];

  function automatic logic [PC_W-1:0] mk_pc(int idx, int hi, int lo);
    return (PC_W'(hi) << (IW + 2)) | (PC_W'(idx) << 2) | PC_W'(lo);
  endfunction

  function automatic logic exp_taken(logic [PC_W-1:0] pc);
    int i = int'(pc[IW+1:2]);
    return m_vld[i] && m_ctr[i][1];
  endfunction

  function automatic logic [PC_W-1:0] exp_tgt(logic [PC_W-1:0] pc);
    int i = int'(pc[IW+1:2]);
    return exp_taken(pc) ? m_tgt[i] : pc + 32'd4;
  endfunction

  task automatic check(string req, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(logic [PC_W-1:0] pc, string req);
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    fetch_pc_i  = pc;
    #1;
    check({req, " taken"}, PC_W'(pred_taken_o), PC_W'(exp_taken(pc)));
    check({req, " target"}, pred_target_o, exp_tgt(pc));
    check("R8 idle flag", PC_W'(mispredict_o), '0);
  endtask

  task automatic update(logic [PC_W-1:0] pc, logic tk, logic [PC_W-1:0] tg,
                        logic ptk, logic [PC_W-1:0] ptg);
    int i = int'(pc[IW+1:2]);
    logic em;
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_pc_i = pc; upd_taken_i = tk; upd_target_i = tg;
    upd_pred_taken_i = ptk; upd_pred_target_i = ptg;
    fetch_pc_i = pc;
    #1;
    em = (tk != ptk) || (tk && ptk && (tg != ptg));
    check("R8 mispredict", PC_W'(mispredict_o), PC_W'(em));
    // R9: same-cycle lookup sees old contents
    check("R9 old taken", PC_W'(pred_taken_o), PC_W'(exp_taken(pc)));
    check("R9 old target", pred_target_o, exp_tgt(pc));
    @(posedge clk_i);
    #0.1;
    if (!m_vld[i]) m_ctr[i] = 2'b01;  // R7 counts from weak not-taken
    if (tk) m_ctr[i] = (m_ctr[i] == 2'b11) ? 2'b11 : m_ctr[i] + 2'd1;  // R3
    else    m_ctr[i] = (m_ctr[i] == 2'b00) ? 2'b00 : m_ctr[i] - 2'd1;  // R4
    m_vld[i] = 1'b1;
    m_tgt[i] = tg;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [9:0] pat;
    for (int i = 0; i < ENT; i++) begin
      m_vld[i] = 1'b0; m_ctr[i] = 2'b01; m_tgt[i] = '0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: every entry after reset
    for (int i = 0; i < ENT; i++) lookup(mk_pc(i, 7, 0), "R1 reset");

    // R7: first taken on a fresh entry flips it to taken at once
    update(mk_pc(3, 1, 0), 1'b1, 32'hA000_0040, 1'b0, mk_pc(3, 1, 0) + 4);
    lookup(mk_pc(3, 1, 0), "R7 first update");
    check("R7 direction", PC_W'(pred_taken_o), 32'd1);

    // R3 R4 R5 R6: outcome walks on every entry, aliasing high bits each step (R2)
    pat = 10'b0000111011;
    for (int i = 0; i < ENT; i++) begin
      for (int s = 0; s < 10; s++) begin
        logic [PC_W-1:0] pc, tg, ptg;
        logic ptk;
        pc  = mk_pc(i, s + 1, s % 4);
        tg  = 32'h8000_0000 + PC_W'(i << 8) + PC_W'(s << 2);
        ptk = exp_taken(pc);
        ptg = exp_tgt(pc);
        if (s == 3) ptk = ~ptk;
        if (s == 5) ptg = ptg ^ 32'h10;
        lookup(pc, "R5 R6 R2 walk");
        update(pc, pat[s], tg, ptk, ptg);
      end
      lookup(mk_pc(i, 99, 0), "R3 R4 R5 after walk");
    end

    // R5: hysteresis from strong taken needs two not-taken outcomes
    for (int k = 0; k < 3; k++)
      update(mk_pc(9, 0, 0), 1'b1, 32'h0000_1230, 1'b1, 32'h0000_1230);
    update(mk_pc(9, 0, 0), 1'b0, 32'h0000_1230, 1'b1, 32'h0000_1230);
    lookup(mk_pc(9, 0, 0), "R5 one wrong");
    check("R5 still taken", PC_W'(pred_taken_o), 32'd1);
    update(mk_pc(9, 0, 0), 1'b0, 32'h0000_1230, 1'b1, 32'h0000_1230);
    lookup(mk_pc(9, 0, 0), "R5 two wrong");
    check("R5 now not taken", PC_W'(pred_taken_o), 32'd0);

    // R2: alias through high bits and byte offset
    lookup(mk_pc(9, 123, 3), "R2 alias");

    // R10: full sweep of the table against the model
    update(mk_pc(4, 2, 0), 1'b1, 32'hDEAD_BEE0, 1'b0, 32'h0);
    update(mk_pc(4, 2, 0), 1'b1, 32'hDEAD_BEE0, 1'b1, 32'hDEAD_BEE0);
    for (int i = 0; i < ENT; i++) lookup(mk_pc(i, 55, 0), "R10 isolation");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule